// File: doc/BRIEF.md
# Message-Signalled Interrupt Pending Bank

This block collects posted message-signalled interrupts and turns them into level interrupt requests for a downstream interrupt controller. A device signals an interrupt by writing one word to the message index register. The top bits of that word pick one of eight banks and the next five bits pick one of the 32 bits inside it, so one write port can address 256 message sources. The chosen bit is ORed into that bank's pending register.

Software services a bank by reading its pending register. The read returns the word and clears it, which drops the bank's interrupt line. A summary register shows which banks hold any pending bit, so a handler can find the busy banks with one read. The register bus carries full 32-bit words only. It has separate read and write strobes in the same cycle, and read data comes back one cycle after the read strobe.

Top module: `msg_irq_bank`

## Requirements
- R1: A write with address 0x140 sets bit wr_data[28:24] of the pending register of bank wr_data[31:29]. The bit is ORed in and other bits of that bank and of all other banks keep their values.
- R2: irq_o[i] is high exactly while pending register i is nonzero, starting the cycle after the write that sets it and ending the cycle after the read that clears it.
- R3: A read at address 0x10*i (i = 0..7) returns the contents of pending register i and clears that register on the same clock edge.
- R4: A read at address 0x120 returns a word whose bit i is 1 when pending register i is nonzero. Bits 31:8 are zero.
- R5: An access whose address has a nonzero low nibble is rejected. Such a write changes nothing, and such a read returns 0xFFFFFFFF and clears nothing.
- R6: Writes to any address other than 0x140 are ignored. Aligned reads of unmapped addresses return zero and change nothing.
- R7: rd_valid is high in the cycle after each read strobe and low otherwise. rd_data is valid while rd_valid is high.
- R8: If a read clears a bank in the same cycle as a message write that sets a bit of that bank, the register afterwards holds only the newly set bit. The read still returns the old contents.
- R9: A synchronous active-high reset clears every pending register, drops all interrupt lines and drops rd_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Byte address of the read |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| irq_o | output | 8 | Level interrupt request per bank |

## Verification
The hardest case to reach is a read-clear of a bank landing on the same edge as a message write into that same bank. A slip there loses a message or brings back cleared bits. The stimulus makes this happen on purpose: it drives both strobes in one cycle while the bank already holds other bits, then reads the bank again to see what survived. A long random phase then mixes reads, message writes, misaligned writes and writes to other offsets. This makes same-bank collisions frequent, and a behavioural model checks every cycle.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
    localparam int NBANK    = 8;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 9;
    localparam int BANK_W   = $clog2(NBANK);
    localparam int BIT_W    = $clog2(REG_W);
    localparam int BANK_LSB = REG_W - BANK_W;
    localparam int BIT_LSB  = BANK_LSB - BIT_W;
    localparam int SLOT_W   = ADDR_W - 4;

    localparam logic [ADDR_W-1:0] OFS_INDEX   = ADDR_W'(9'h140);
    localparam logic [ADDR_W-1:0] OFS_SUMMARY = ADDR_W'(9'h120);

    typedef enum logic [1:0] {
        RD_ZERO    = 2'd0,
        RD_BANK    = 2'd1,
        RD_SUMMARY = 2'd2,
        RD_ONES    = 2'd3
    } rd_kind_e;

    typedef struct packed {
        rd_kind_e           kind;
        logic [BANK_W-1:0]  bank;
    } rd_dec_t;

    typedef struct packed {
        logic               en;
        logic [BANK_W-1:0]  bank;
        logic [BIT_W-1:0]   bit_idx;
    } set_req_t;

    function automatic logic is_aligned(input logic [ADDR_W-1:0] a);
        return a[3:0] == 4'h0;
    endfunction
endpackage

// File: rtl/msg_irq_decode.sv
module msg_irq_decode
    import msg_irq_pkg::*;
(
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output rd_dec_t           rd_dec,
    output logic [NBANK-1:0]  clr_vec,
    output set_req_t          set_req
);
    logic [SLOT_W-1:0] slot;

    assign slot = rd_addr[ADDR_W-1:4];

    always_comb begin
        rd_dec.kind = RD_ZERO;
        rd_dec.bank = rd_addr[4 +: BANK_W];
        clr_vec     = '0;
        if (!is_aligned(rd_addr)) begin
            rd_dec.kind = RD_ONES;
        end else if (int'(slot) < NBANK) begin
            rd_dec.kind = RD_BANK;
            clr_vec[rd_dec.bank] = rd_en;
        end else if (rd_addr == OFS_SUMMARY) begin
            rd_dec.kind = RD_SUMMARY;
        end
    end

    always_comb begin
        set_req.en      = wr_en && (wr_addr == OFS_INDEX);
        set_req.bank    = wr_data[BANK_LSB +: BANK_W];
        set_req.bit_idx = wr_data[BIT_LSB +: BIT_W];
    end
endmodule

// File: rtl/msg_irq_pend.sv
module msg_irq_pend
    import msg_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              set_en,
    input  logic [BIT_W-1:0]  set_bit,
    output logic [REG_W-1:0]  pend
);
    logic [REG_W-1:0] set_mask;
    logic [REG_W-1:0] pend_d;

    always_comb begin
        set_mask = set_en ? (REG_W'(1) << set_bit) : '0;
        pend_d   = (clr ? '0 : pend) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_d;
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        set_en |=> pend[$past(set_bit)]); // R1

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_en) |=> (pend == '0)); // R3

    AST_SET_SURVIVES_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && set_en) |=> (pend == (REG_W'(1) << $past(set_bit)))); // R8
endmodule

// File: rtl/msg_irq_rdback.sv
module msg_irq_rdback
    import msg_irq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  rd_dec_t                     rd_dec,
    input  logic [NBANK-1:0][REG_W-1:0] pend,
    output logic                        rd_valid,
    output logic [REG_W-1:0]            rd_data
);
    logic [NBANK-1:0] busy;
    logic [REG_W-1:0] rd_word;

    for (genvar g = 0; g < NBANK; g++) begin : g_busy
        assign busy[g] = |pend[g];
    end

    always_comb begin
        unique case (rd_dec.kind)
            RD_BANK:    rd_word = pend[rd_dec.bank];
            RD_SUMMARY: rd_word = REG_W'(busy);
            RD_ONES:    rd_word = '1;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_word;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R7

    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R7

    AST_MISALIGNED_ONES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_dec.kind == RD_ONES) |=> (rd_data == '1)); // R5

    AST_SUMMARY_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_dec.kind == RD_SUMMARY) |=> (rd_data[REG_W-1:NBANK] == '0)); // R4
endmodule

// File: rtl/msg_irq_bank.sv
module msg_irq_bank
    import msg_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              rd_valid,
    output logic [REG_W-1:0]  rd_data,
    output logic [NBANK-1:0]  irq_o
);
    rd_dec_t                     rd_dec;
    set_req_t                    set_req;
    logic [NBANK-1:0]            clr_vec;
    logic [NBANK-1:0][REG_W-1:0] pend;

    msg_irq_decode u_decode (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_dec  (rd_dec),
        .clr_vec (clr_vec),
        .set_req (set_req)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        msg_irq_pend u_pend (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr_vec[b]),
            .set_en  (set_req.en && (set_req.bank == BANK_W'(b))),
            .set_bit (set_req.bit_idx),
            .pend    (pend[b])
        );
        assign irq_o[b] = |pend[b];
    end

    msg_irq_rdback u_rdback (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_dec   (rd_dec),
        .pend     (pend),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && !rd_valid)); // R9

    AST_STRAY_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !(wr_en && wr_addr == OFS_INDEX)) |=> $stable(irq_o)); // R6
endmodule

// File: tb/msg_irq_bank_tb_top.sv
module msg_irq_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  irq_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] m_pend [8];
    logic        e_valid;
    logic [31:0] e_data;

    always #5 clk = ~clk;

    msg_irq_bank dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [7:0] m_irq();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = (m_pend[i] != 0);
        return r;
    endfunction

    task automatic compare(input string tag);
        vectors++;
        if (rd_valid !== e_valid) begin
            fails++;
            $display("FAIL %s rd_valid actual=%0b expected=%0b", tag, rd_valid, e_valid);
        end
        if (e_valid && rd_data !== e_data) begin
            fails++;
            $display("FAIL %s rd_data actual=%08h expected=%08h", tag, rd_data, e_data);
        end
        if (irq_o !== m_irq()) begin
            fails++;
            $display("FAIL %s irq_o actual=%02h expected=%02h", tag, irq_o, m_irq());
        end
    endtask

    task automatic step(input string tag, input logic re, input logic [8:0] ra,
                        input logic we, input logic [8:0] wa, input logic [31:0] wd);
        @(negedge clk);
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        e_valid = re;
        if (re) begin
            if (ra[3:0] != 0)        e_data = 32'hFFFF_FFFF;
            else if (ra < 9'h080) begin
                e_data = m_pend[ra[6:4]];
                m_pend[ra[6:4]] = '0;
            end else if (ra == 9'h120) e_data = {24'h0, m_irq()};
            else                       e_data = '0;
        end
        if (we && wa == 9'h140) m_pend[wd[31:29]] |= (32'h1 << wd[28:24]);
        #1;
        compare(tag);
    endtask

    function automatic logic [31:0] msg(input int bank, input int b);
        return {3'(bank), 5'(b), 24'h5A5A5A};
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) m_pend[i] = '0;
        e_valid = 1'b0; e_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1; compare("R9 reset state");
        step("R4 summary empty", 1, 9'h120, 0, 0, 0);
        step("R1 set bank3 bit7", 0, 0, 1, 9'h140, msg(3, 7));
        step("R1 set bank3 bit31", 0, 0, 1, 9'h140, msg(3, 31));
        step("R1 set bank0 bit0", 0, 0, 1, 9'h140, msg(0, 0));
        step("R2 set bank7 bit15", 0, 0, 1, 9'h140, msg(7, 15));
        step("R4 summary three banks", 1, 9'h120, 0, 0, 0);
        step("R5 misaligned write", 0, 0, 1, 9'h141, msg(5, 1));
        step("R5 misaligned read", 1, 9'h034, 0, 0, 0);
        step("R6 write to bank offset", 0, 0, 1, 9'h030, 32'hFFFF_FFFF);
        step("R6 write to summary", 0, 0, 1, 9'h120, 32'hFFFF_FFFF);
        step("R6 unmapped read", 1, 9'h1F0, 0, 0, 0);
        step("R3 read bank3", 1, 9'h030, 0, 0, 0);
        step("R3 reread bank3 empty", 1, 9'h030, 0, 0, 0);
        step("R7 idle cycle", 0, 0, 0, 0, 0);
        step("R1 set bank5 bit2", 0, 0, 1, 9'h140, msg(5, 2));
        step("R8 clear with set same bank", 1, 9'h050, 1, 9'h140, msg(5, 9));
        step("R8 surviving bit", 1, 9'h050, 0, 0, 0);
        step("R3 read bank0", 1, 9'h000, 0, 0, 0);
        step("R3 read bank7", 1, 9'h070, 0, 0, 0);
        step("R2 all quiet summary", 1, 9'h120, 0, 0, 0);
        for (int n = 0; n < 600; n++) begin
            logic [8:0] ra, wa;
            int pick;
            pick = $urandom_range(0, 11);
            if (pick < 8)       ra = 9'(pick * 16);
            else if (pick == 8) ra = 9'h120;
            else if (pick == 9) ra = 9'h140;
            else if (pick == 10) ra = 9'h00C;
            else                ra = 9'h1F0;
            pick = $urandom_range(0, 5);
            wa = (pick < 4) ? 9'h140 : (pick == 4 ? 9'h148 : 9'h020);
            step("R1 R3 R8 random", 1'($urandom_range(0, 1)), ra,
                 1'($urandom_range(0, 1)), wa, $urandom);
        end
        @(negedge clk); rst = 1'b1; rd_en = 0; wr_en = 0;
        @(posedge clk);
        for (int i = 0; i < 8; i++) m_pend[i] = '0;
        e_valid = 1'b0;
        #1; compare("R9 reset clears");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule